// File: doc/BRIEF.md
# Time Interval Event Detector

This block keeps a time-of-day count of seconds, minutes and hours, advanced by a one-pulse-per-second strobe. From that count it raises an interval event at one of four points. A 2-bit select code chooses the point: every minute change, every hour change, the daily roll to midnight, or the daily arrival at noon. The event appears as a single-cycle pulse and also sets a sticky flag. The flag stays set until software clears it or the interrupt vector logic acknowledges it. An enable bit decides whether the flag reaches the interrupt request output.

The three counters can be preset through a load strobe, as software does when it sets the clock. The counter encoding is a build-time choice between plain binary and packed BCD, with the tens digit in the upper nibble. Detection uses the carries that the counters already produce. Because of that, a preset or a change of the select code never creates an event by itself.

Top module: `tev_interval_alarm`

## Requirements
- R1: Seconds and minutes count 0 to 59 and hours count 0 to 23. Each field advances when the one below it wraps, the seconds field advances on every tick, and 23:59:59 rolls over to 00:00:00.
- R2: With USE_BCD=0 each field holds its value in plain binary. With USE_BCD=1 each field holds packed BCD: tens in bits 7:4 and units in bits 3:0.
- R3: Select code 0 raises an event on every tick that changes the minutes value, which is the tick taking seconds from 59 to 0.
- R4: Select code 1 raises an event on every tick that changes the hours value, which is the tick taking mm:ss from 59:59 to 00:00.
- R5: Select code 2 raises an event only on the tick that makes the time 00:00:00.
- R6: Select code 3 raises an event only on the tick that makes the time 12:00:00.
- R7: The event pulse is high for exactly one cycle. That cycle is the one in which the new time value first appears on the time outputs.
- R8: The event sets the flag in the same cycle as the pulse. The flag holds until a software clear or a vector acknowledge removes it. If an event and a clear or acknowledge fall in the same cycle, the flag ends up set.
- R9: The interrupt request is high exactly when the flag is set and the enable is high.
- R10: A change of the select code with no tick produces no event.
- R11: A load strobe writes the three load values into the counters on the next edge and produces no event. A load in the same cycle as a tick takes precedence over the tick.
- R12: After a synchronous reset the time is 00:00:00 and the pulse, flag and request are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| time_ld | input | 1 | Preset strobe for the time fields |
| ld_hr | input | 8 | Hours preset value |
| ld_min | input | 8 | Minutes preset value |
| ld_sec | input | 8 | Seconds preset value |
| ev_sel | input | 2 | Event select: 0 minute, 1 hour, 2 midnight, 3 noon |
| ev_en | input | 1 | Lets the flag drive the request |
| flag_clr | input | 1 | Software clear of the flag |
| flag_ack | input | 1 | Vector-logic acknowledge of the flag |
| cur_hr | output | 8 | Current hours |
| cur_min | output | 8 | Current minutes |
| cur_sec | output | 8 | Current seconds |
| ev_pulse | output | 1 | Single-cycle event pulse |
| ev_flag | output | 1 | Sticky event flag |
| ev_irq | output | 1 | Interrupt request |

## Verification
Two kinds of collision can fall in one cycle.

- **Event against flag removal.** A rollover event can coincide with a software clear or a vector acknowledge. The bench forces this with directed steps that put a clear on the rollover tick. The rule is that the flag ends set.
- **Preset against tick.** A preset can coincide with a tick. The bench expects the loaded time to win and no pulse to appear.

The random phase lands both collisions repeatedly. It biases presets toward xx:59:59, 11:59:59 and 23:59:59, and sprinkles clears and acknowledges at random. An independent bench model of the clock, the event and the flag judges every cycle.

// File: rtl/tev_pkg.sv
// Shared definitions for the interval event detector.
// Assumes: every time field fits in FIELD_W bits in both encodings.
package tev_pkg;
    localparam int FIELD_W = 8;

    typedef enum logic [1:0] {
        SEL_MINUTE   = 2'd0,
        SEL_HOUR     = 2'd1,
        SEL_MIDNIGHT = 2'd2,
        SEL_NOON     = 2'd3
    } tev_sel_e;

    // Encode an integer 0..99 as binary or as packed two-digit BCD.
    function automatic logic [FIELD_W-1:0] tev_enc(input int n, input bit bcd);
        logic [FIELD_W-1:0] r;
        if (bcd) r = FIELD_W'(((n / 10) << 4) | (n % 10));
        else     r = FIELD_W'(n);
        return r;
    endfunction
endpackage

// File: rtl/tev_unit_ctr.sv
// One time field: counts 0..MAX, wraps to 0, accepts a preset.
// Assumes: preset values are valid for the chosen encoding and below MAX+1.
module tev_unit_ctr
    import tev_pkg::*;
#(
    parameter int MAX     = 59,
    parameter bit USE_BCD = 1'b0,
    parameter int W       = FIELD_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] value,
    output logic         wrap
);
    localparam logic [W-1:0] TOP = W'(tev_enc(MAX, USE_BCD));

    logic [W-1:0] nxt;

    // Wrap is this field's carry: it advances and sits at its top value.
    assign wrap = inc && (value == TOP);

    // Next value for the selected encoding.
    generate
        if (USE_BCD) begin : g_bcd
            always_comb nxt = (value[3:0] == 4'd9) ? {value[W-1:4] + 1'b1, 4'b0000}
                                                   : value + 1'b1;
        end else begin : g_bin
            always_comb nxt = value + 1'b1;
        end
    endgenerate

    // Field register: reset, then preset, then count.
    always_ff @(posedge clk) begin
        if (!rst_n)    value <= '0;
        else if (load) value <= load_val;
        else if (inc)  value <= wrap ? '0 : nxt;
    end

    assert_in_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        value <= TOP);
    assert_wrap_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wrap && !load |=> value == '0);
endmodule

// File: rtl/tev_detect.sv
// Picks the interval event from the field carries by select code.
// Assumes: carries are already gated by tick and preset (no event on preset).
module tev_detect
    import tev_pkg::*;
#(
    parameter bit USE_BCD = 1'b0,
    parameter int W       = FIELD_W
) (
    input  logic         sec_wrap,
    input  logic         min_wrap,
    input  logic         hr_wrap,
    input  logic [W-1:0] hr_val,
    input  tev_sel_e     sel,
    output logic         hit
);
    localparam logic [W-1:0] HR_BEFORE_NOON = W'(tev_enc(11, USE_BCD));

    // Select one of the four rollover conditions.
    always_comb begin
        unique case (sel)
            SEL_MINUTE:   hit = sec_wrap;
            SEL_HOUR:     hit = min_wrap;
            SEL_MIDNIGHT: hit = hr_wrap;
            SEL_NOON:     hit = min_wrap && (hr_val == HR_BEFORE_NOON);
            default:      hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/tev_flag.sv
// Sticky event flag; set wins over clear and acknowledge.
// Assumes: set, clr and ack are synchronous single-cycle requests.
module tev_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic ack,
    output logic flag
);
    // Hold the flag until removed; a same-cycle event keeps it set.
    always_ff @(posedge clk) begin
        if (!rst_n)          flag <= 1'b0;
        else if (set)        flag <= 1'b1;
        else if (clr || ack) flag <= 1'b0;
    end

    assert_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr || ack) && !set |=> !flag);
endmodule

// File: rtl/tev_interval_alarm.sv
// Time-of-day counter with a selectable interval event, pulse, flag and request.
// Assumes: sec_tick is one cycle wide; preset values are valid time fields.
module tev_interval_alarm
    import tev_pkg::*;
#(
    parameter bit USE_BCD = 1'b0,
    parameter int W       = FIELD_W,
    parameter int SEC_MAX = 59,
    parameter int MIN_MAX = 59,
    parameter int HR_MAX  = 23
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sec_tick,
    input  logic         time_ld,
    input  logic [W-1:0] ld_hr,
    input  logic [W-1:0] ld_min,
    input  logic [W-1:0] ld_sec,
    input  logic [1:0]   ev_sel,
    input  logic         ev_en,
    input  logic         flag_clr,
    input  logic         flag_ack,
    output logic [W-1:0] cur_hr,
    output logic [W-1:0] cur_min,
    output logic [W-1:0] cur_sec,
    output logic         ev_pulse,
    output logic         ev_flag,
    output logic         ev_irq
);
    localparam logic [W-1:0] HR_NOON = W'(tev_enc(12, USE_BCD));

    logic     adv;
    logic     sec_wrap, min_wrap, hr_wrap;
    logic     hit;
    tev_sel_e sel;

    assign sel = tev_sel_e'(ev_sel);
    assign adv = sec_tick && !time_ld;

    tev_unit_ctr #(.MAX(SEC_MAX), .USE_BCD(USE_BCD), .W(W)) u_sec (
        .clk(clk), .rst_n(rst_n), .inc(adv), .load(time_ld),
        .load_val(ld_sec), .value(cur_sec), .wrap(sec_wrap));

    tev_unit_ctr #(.MAX(MIN_MAX), .USE_BCD(USE_BCD), .W(W)) u_min (
        .clk(clk), .rst_n(rst_n), .inc(sec_wrap), .load(time_ld),
        .load_val(ld_min), .value(cur_min), .wrap(min_wrap));

    tev_unit_ctr #(.MAX(HR_MAX), .USE_BCD(USE_BCD), .W(W)) u_hr (
        .clk(clk), .rst_n(rst_n), .inc(min_wrap), .load(time_ld),
        .load_val(ld_hr), .value(cur_hr), .wrap(hr_wrap));

    tev_detect #(.USE_BCD(USE_BCD), .W(W)) u_det (
        .sec_wrap(sec_wrap), .min_wrap(min_wrap), .hr_wrap(hr_wrap),
        .hr_val(cur_hr), .sel(sel), .hit(hit));

    tev_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set(hit), .clr(flag_clr),
        .ack(flag_ack), .flag(ev_flag));

    // Register the event so it lines up with the new time value.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_pulse <= 1'b0;
        else        ev_pulse <= hit;
    end

    // Gate the flag into the request with the enable.
    always_comb ev_irq = ev_flag && ev_en;

    assert_load_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        time_ld |=> !ev_pulse);
    assert_no_tick_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sec_tick |=> !ev_pulse);
    assert_single_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse |=> !ev_pulse);
    assert_midnight_time_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse && ($past(sel) == SEL_MIDNIGHT) |->
            (cur_hr == '0) && (cur_min == '0) && (cur_sec == '0));
    assert_noon_time_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse && ($past(sel) == SEL_NOON) |->
            (cur_hr == HR_NOON) && (cur_min == '0) && (cur_sec == '0));
    assert_minute_time_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_pulse && ($past(sel) == SEL_MINUTE) |-> cur_sec == '0);
endmodule

// File: tb/sim_tev_interval_alarm.sv
module sim_tev_interval_alarm;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, ld = 1'b0, en = 1'b0, clr = 1'b0, ack = 1'b0;
    logic [1:0] sel = 2'd0;
    int         ld_h = 0, ld_m = 0, ld_s = 0;

    logic [7:0] b_hr, b_min, b_sec, d_hr, d_min, d_sec;
    logic       b_pulse, b_flag, b_irq, d_pulse, d_flag, d_irq;

    int n_checks = 0, n_fail = 0;
    int m_h = 0, m_m = 0, m_s = 0;
    bit m_pulse = 0, m_flag = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] enc(input int n, input bit bcd);
        return bcd ? 8'(((n / 10) * 16) + (n % 10)) : 8'(n);
    endfunction

    tev_interval_alarm u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(tick), .time_ld(ld),
        .ld_hr(enc(ld_h, 0)), .ld_min(enc(ld_m, 0)), .ld_sec(enc(ld_s, 0)),
        .ev_sel(sel), .ev_en(en), .flag_clr(clr), .flag_ack(ack),
        .cur_hr(b_hr), .cur_min(b_min), .cur_sec(b_sec),
        .ev_pulse(b_pulse), .ev_flag(b_flag), .ev_irq(b_irq));

    tev_interval_alarm #(.USE_BCD(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .sec_tick(tick), .time_ld(ld),
        .ld_hr(enc(ld_h, 1)), .ld_min(enc(ld_m, 1)), .ld_sec(enc(ld_s, 1)),
        .ev_sel(sel), .ev_en(en), .flag_clr(clr), .flag_ack(ack),
        .cur_hr(d_hr), .cur_min(d_min), .cur_sec(d_sec),
        .ev_pulse(d_pulse), .ev_flag(d_flag), .ev_irq(d_irq));

    task automatic chk(input string tag, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
        end
    endtask

    // Advance the bench model across one clock edge from the driven inputs.
    task automatic model_edge();
        bit hit = 0;
        if (ld) begin
            m_h = ld_h; m_m = ld_m; m_s = ld_s;
        end else if (tick) begin
            bit mc = (m_s == 59);
            bit hc = mc && (m_m == 59);
            case (sel)
                2'd0: hit = mc;
                2'd1: hit = hc;
                2'd2: hit = hc && (m_h == 23);
                default: hit = hc && (m_h == 11);
            endcase
            m_s = (m_s + 1) % 60;
            if (mc) m_m = (m_m + 1) % 60;
            if (hc) m_h = (m_h + 1) % 24;
        end
        m_pulse = hit;
        if (hit) m_flag = 1;
        else if (clr || ack) m_flag = 0;
    endtask

    task automatic compare(input string tag);
        chk({"R1 R2 hours bin ", tag}, b_hr, enc(m_h, 0));
        chk({"R1 R2 minutes bin ", tag}, b_min, enc(m_m, 0));
        chk({"R1 R2 seconds bin ", tag}, b_sec, enc(m_s, 0));
        chk({"R2 hours bcd ", tag}, d_hr, enc(m_h, 1));
        chk({"R2 minutes bcd ", tag}, d_min, enc(m_m, 1));
        chk({"R2 seconds bcd ", tag}, d_sec, enc(m_s, 1));
        chk({"R7 pulse ", tag}, b_pulse, m_pulse);
        chk({"R7 pulse bcd ", tag}, d_pulse, m_pulse);
        chk({"R8 flag ", tag}, b_flag, m_flag);
        chk({"R9 irq ", tag}, b_irq, m_flag && en);
    endtask

    task automatic step(input string tag);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(tag);
        tick = 0; ld = 0; clr = 0; ack = 0;
    endtask

    task automatic preset(input int h, input int m, input int s);
        ld = 1; ld_h = h; ld_m = m; ld_s = s;
        step("R11 preset");
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare("R12 reset state");

        en = 1; sel = 2'd2;
        preset(23, 59, 59);
        tick = 1; step("R5 midnight rollover");
        step("R7 pulse drops, R8 flag holds");
        ack = 1; step("R8 ack clears");

        sel = 2'd3;
        preset(10, 59, 59);
        tick = 1; step("R6 no event at 11:00");
        preset(11, 59, 59);
        tick = 1; step("R6 noon");
        clr = 1; step("R8 software clear");

        sel = 2'd1;
        preset(5, 59, 59);
        tick = 1; step("R4 hour change");
        clr = 1; sel = 2'd0;
        preset(5, 10, 59);
        tick = 1; step("R3 minute change");
        tick = 1; step("R3 no change mid-minute");

        clr = 1; step("R8 clear");
        preset(0, 0, 59);
        tick = 1; clr = 1; step("R8 set wins over clear");
        preset(0, 1, 59);
        tick = 1; ack = 1; step("R8 set wins over ack");

        for (int k = 0; k < 8; k++) begin
            sel = 2'(k); step("R10 select change quiet");
        end

        en = 0; sel = 2'd0; ack = 1; step("R8 clear before R9");
        preset(3, 3, 59);
        tick = 1; step("R9 flag set, request gated");
        en = 1; step("R9 request follows enable");

        sel = 2'd0;
        preset(7, 7, 59);
        ld = 1; ld_h = 7; ld_m = 7; ld_s = 59; tick = 1;
        step("R11 preset beats tick");

        for (int i = 0; i < 4000; i++) begin
            tick = ($urandom_range(3, 0) != 0);
            if ($urandom_range(19, 0) == 0) sel = 2'($urandom_range(3, 0));
            if ($urandom_range(9, 0) == 0) en = ~en;
            clr = ($urandom_range(29, 0) == 0);
            ack = ($urandom_range(29, 0) == 0);
            if ($urandom_range(39, 0) == 0) begin
                int pick = $urandom_range(3, 0);
                ld = 1;
                ld_s = ($urandom_range(1, 0) != 0) ? 59 : $urandom_range(59, 0);
                ld_m = ($urandom_range(1, 0) != 0) ? 59 : $urandom_range(59, 0);
                ld_h = (pick == 0) ? 23 : (pick == 1) ? 11 : $urandom_range(23, 0);
            end
            step("random R3 R4 R5 R6");
        end

        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end
endmodule